// File: doc/BRIEF.md
# Out-of-Order Dispatch Scheduler

This block sits between register renaming and the execution units of an out-of-order core. It holds up to twenty renamed micro-operations, each with an operation class, a destination tag and two source operands. A source is either present when the micro-operation arrives, carrying its value, or pending, carrying the tag of the result it waits for. Five result buses come back from the execution units. When a tag on one of them matches a pending source, the value is captured and the source becomes present.

Up to three micro-operations enter per cycle through three allocation lanes. If the free entries cannot hold every lane presented, the whole group is refused. Entries whose operands are all present are registered as ready. In the following cycle, each of five execution ports picks its oldest ready entry, unless that port is marked busy. The ports serve different operation classes. A port can dispatch at most one micro-operation per cycle, so up to five leave together. A flush empties the whole scheduler.

Top module: `rs_sched`

## Requirements
- R1: After reset no port dispatches, and a three-lane allocation request is not stalled, because all twenty entries are free.
- R2: A micro-operation written with both sources present appears on its port two clock edges after the edge that writes it, and not earlier. The port shows its operation class, destination tag and both source values.
- R3: A pending source captures the value from any result bus whose valid bit is set and whose tag matches. This also applies in the cycle the micro-operation is written. The micro-operation dispatches two edges after the capturing edge.
- R4: Operation class codes are ALU=0, SHIFT=1, FP=2, IMUL=3, AGU=4, LOAD=5, STA=6, STD=7. Port 0 serves ALU, SHIFT, FP, IMUL and AGU. Port 1 serves ALU. Ports 2, 3 and 4 serve LOAD, STA and STD respectively. Port 1 takes the oldest ready ALU operation, and port 0 may take a different one in the same cycle.
- R5: When several ready micro-operations compete for one port, the earliest allocated wins. Within one allocation group, a lower lane counts as earlier.
- R6: A port whose busy input is high during a cycle dispatches nothing at the next edge. Its waiting micro-operation stays held and dispatches on the edge after the busy input drops.
- R7: All five ports can dispatch in the same cycle, one micro-operation each.
- R8: The stall output is high, in the same cycle, whenever the free entries are fewer than the number of valid allocation lanes. While it is high, no lane is written.
- R9: A flush invalidates every entry and clears the dispatch outputs at the next edge. Flushed micro-operations never dispatch, and all twenty entries become free.
- R10: Each micro-operation dispatches exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| alloc_valid | input | 3 | Lane valid bits |
| alloc_op | input | 3x3 | Operation class per lane |
| alloc_dst | input | 3x6 | Destination tag per lane |
| alloc_src1_tag | input | 3x6 | First source tag per lane |
| alloc_src1_rdy | input | 3 | First source present |
| alloc_src1_val | input | 3x16 | First source value |
| alloc_src2_tag | input | 3x6 | Second source tag per lane |
| alloc_src2_rdy | input | 3 | Second source present |
| alloc_src2_val | input | 3x16 | Second source value |
| alloc_stall | output | 1 | Group refused this cycle |
| wb_valid | input | 5 | Result bus valid bits |
| wb_tag | input | 5x6 | Result bus tags |
| wb_data | input | 5x16 | Result bus values |
| port_busy | input | 5 | Execution port unavailable |
| disp_valid | output | 5 | Dispatch valid per port |
| disp_op | output | 5x3 | Dispatched operation class |
| disp_dst | output | 5x6 | Dispatched destination tag |
| disp_src1 | output | 5x16 | Dispatched first source value |
| disp_src2 | output | 5x16 | Dispatched second source value |

## Verification
Every result has a fixed latency. Dispatch comes two edges after a write or a capturing broadcast: one edge registers readiness and one registers the pick. A busy port releases one edge after it drops, and a flush takes effect at the next edge. The stall is combinational, so it is read in the same cycle the lanes are presented. The bench drives inputs on the falling edge and reads outputs on later falling edges at exactly those edge counts. It also checks the edge before each expected dispatch, to confirm nothing appears early, and the edge after it, to confirm the micro-operation leaves only once.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int RS_PORTS  = 5;
    localparam int RS_TAG_W  = 6;
    localparam int RS_DATA_W = 16;
    localparam int RS_OP_W   = 3;

    typedef enum logic [RS_OP_W-1:0] {
        OP_ALU   = 3'd0,
        OP_SHIFT = 3'd1,
        OP_FP    = 3'd2,
        OP_IMUL  = 3'd3,
        OP_AGU   = 3'd4,
        OP_LOAD  = 3'd5,
        OP_STA   = 3'd6,
        OP_STD   = 3'd7
    } op_class_e;

    typedef logic [RS_OP_W-1:0]   op_t;
    typedef logic [RS_TAG_W-1:0]  tag_t;
    typedef logic [RS_DATA_W-1:0] data_t;

    typedef struct packed {
        tag_t  tag;
        logic  rdy;
        data_t val;
    } src_t;

    typedef struct packed {
        op_t  op;
        tag_t dst;
        src_t s1;
        src_t s2;
    } uop_t;

    // Which operation classes each execution port accepts.
    function automatic logic port_serves(int port, op_t op);
        logic r;
        case (port)
            0:       r = (op == OP_ALU) || (op == OP_SHIFT) || (op == OP_FP) ||
                         (op == OP_IMUL) || (op == OP_AGU);
            1:       r = (op == OP_ALU);
            2:       r = (op == OP_LOAD);
            3:       r = (op == OP_STA);
            4:       r = (op == OP_STD);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // Capture a result bus value into a pending source on tag match.
    function automatic src_t wake_src(src_t s,
                                      logic [RS_PORTS-1:0] wv,
                                      logic [RS_PORTS-1:0][RS_TAG_W-1:0] wt,
                                      logic [RS_PORTS-1:0][RS_DATA_W-1:0] wd);
        src_t r;
        r = s;
        for (int p = 0; p < RS_PORTS; p++) begin
            if (!r.rdy && wv[p] && (wt[p] == s.tag)) begin
                r.rdy = 1'b1;
                r.val = wd[p];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rs_slot_finder.sv
module rs_slot_finder #(
    parameter int N     = 20,
    parameter int LANES = 3,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]                 occ,
    input  logic [LANES-1:0]             req,
    output logic                         stall,
    output logic [LANES-1:0]             lane_we,
    output logic [LANES-1:0][IDX_W-1:0]  lane_idx
);

    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] need_cnt;
    logic [N-1:0]     taken;
    logic             found;

    always_comb begin
        free_cnt = '0;
        need_cnt = '0;
        for (int i = 0; i < N; i++) begin
            if (!occ[i]) free_cnt = free_cnt + CNT_W'(1);
        end
        for (int k = 0; k < LANES; k++) begin
            if (req[k]) need_cnt = need_cnt + CNT_W'(1);
        end
        stall = (free_cnt < need_cnt);

        taken    = occ;
        lane_we  = '0;
        lane_idx = '0;
        found    = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            found = 1'b0;
            if (req[k] && !stall) begin
                for (int i = 0; i < N; i++) begin
                    if (!taken[i] && !found) begin
                        found       = 1'b1;
                        lane_idx[k] = IDX_W'(i);
                    end
                end
                if (found) begin
                    taken[lane_idx[k]] = 1'b1;
                    lane_we[k]         = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rs_age_matrix.sv
module rs_age_matrix #(
    parameter int N     = 20,
    parameter int LANES = 3,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N-1:0]                 occ,
    input  logic [LANES-1:0]             lane_we,
    input  logic [LANES-1:0][IDX_W-1:0]  lane_idx,
    output logic [N-1:0][N-1:0]          older
);

    // older[j][i] set: entry j was allocated before entry i
    logic [N-1:0][N-1:0] older_q;
    logic [N-1:0][N-1:0] older_d;
    logic [N-1:0]        prior;

    always_comb begin
        older_d = older_q;
        prior   = occ;
        for (int k = 0; k < LANES; k++) begin
            if (lane_we[k]) begin
                for (int j = 0; j < N; j++) begin
                    older_d[j][lane_idx[k]] = prior[j];
                    older_d[lane_idx[k]][j] = 1'b0;
                end
                prior[lane_idx[k]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) older_q <= '0;
        else     older_q <= older_d;
    end

    assign older = older_q;

endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
    parameter int N = 20
) (
    input  logic [N-1:0]        req,
    input  logic [N-1:0][N-1:0] older,
    output logic [N-1:0]        gnt
);

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic blocked;
        always_comb begin
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (req[j] && older[j][i]) blocked = 1'b1;
            end
        end
        assign gnt[i] = req[i] && !blocked;
    end

endmodule

// File: rtl/rs_sched.sv
module rs_sched
    import rs_pkg::*;
#(
    parameter int ENTRIES = 20,
    parameter int LANES   = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  flush,
    input  logic [LANES-1:0]                      alloc_valid,
    input  logic [LANES-1:0][RS_OP_W-1:0]         alloc_op,
    input  logic [LANES-1:0][RS_TAG_W-1:0]        alloc_dst,
    input  logic [LANES-1:0][RS_TAG_W-1:0]        alloc_src1_tag,
    input  logic [LANES-1:0]                      alloc_src1_rdy,
    input  logic [LANES-1:0][RS_DATA_W-1:0]       alloc_src1_val,
    input  logic [LANES-1:0][RS_TAG_W-1:0]        alloc_src2_tag,
    input  logic [LANES-1:0]                      alloc_src2_rdy,
    input  logic [LANES-1:0][RS_DATA_W-1:0]       alloc_src2_val,
    output logic                                  alloc_stall,
    input  logic [RS_PORTS-1:0]                   wb_valid,
    input  logic [RS_PORTS-1:0][RS_TAG_W-1:0]     wb_tag,
    input  logic [RS_PORTS-1:0][RS_DATA_W-1:0]    wb_data,
    input  logic [RS_PORTS-1:0]                   port_busy,
    output logic [RS_PORTS-1:0]                   disp_valid,
    output logic [RS_PORTS-1:0][RS_OP_W-1:0]      disp_op,
    output logic [RS_PORTS-1:0][RS_TAG_W-1:0]     disp_dst,
    output logic [RS_PORTS-1:0][RS_DATA_W-1:0]    disp_src1,
    output logic [RS_PORTS-1:0][RS_DATA_W-1:0]    disp_src2
);

    // Entry state
    logic [ENTRIES-1:0]               valid_q;
    logic [ENTRIES-1:0]               ready_q;
    uop_t [ENTRIES-1:0]               uop_q;

    // Allocation
    logic [LANES-1:0]                 lane_we;
    logic [LANES-1:0][IDX_W-1:0]      lane_idx;
    uop_t [LANES-1:0]                 lane_uop;
    logic [ENTRIES-1:0]               wr_en;
    uop_t [ENTRIES-1:0]               wr_uop;

    // Selection
    logic [ENTRIES-1:0][ENTRIES-1:0]  older;
    logic [ENTRIES-1:0]               ready_now;
    logic [RS_PORTS-1:0][ENTRIES-1:0] gnt;
    logic [ENTRIES-1:0]               gnt_alu1;
    logic [ENTRIES-1:0]               taken_any;
    uop_t [RS_PORTS-1:0]              pick_uop;

    // Dispatch registers
    logic [RS_PORTS-1:0]              disp_v_q;
    uop_t [RS_PORTS-1:0]              disp_uop_q;

    rs_slot_finder #(.N(ENTRIES), .LANES(LANES)) u_slots (
        .occ      (valid_q),
        .req      (alloc_valid),
        .stall    (alloc_stall),
        .lane_we  (lane_we),
        .lane_idx (lane_idx)
    );

    rs_age_matrix #(.N(ENTRIES), .LANES(LANES)) u_age (
        .clk      (clk),
        .rst      (rst),
        .occ      (valid_q),
        .lane_we  (lane_we),
        .lane_idx (lane_idx),
        .older    (older)
    );

    // Incoming lanes, with same-cycle capture from the result buses
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            lane_uop[k].op  = alloc_op[k];
            lane_uop[k].dst = alloc_dst[k];
            lane_uop[k].s1  = wake_src(src_t'{tag: alloc_src1_tag[k], rdy: alloc_src1_rdy[k],
                                              val: alloc_src1_val[k]}, wb_valid, wb_tag, wb_data);
            lane_uop[k].s2  = wake_src(src_t'{tag: alloc_src2_tag[k], rdy: alloc_src2_rdy[k],
                                              val: alloc_src2_val[k]}, wb_valid, wb_tag, wb_data);
        end
    end

    always_comb begin
        wr_en  = '0;
        wr_uop = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_we[k]) begin
                wr_en[lane_idx[k]]  = 1'b1;
                wr_uop[lane_idx[k]] = lane_uop[k];
            end
        end
    end

    // Stage one: which entries hold all operands
    for (genvar i = 0; i < ENTRIES; i++) begin : g_rdy
        assign ready_now[i] = valid_q[i] && uop_q[i].s1.rdy && uop_q[i].s2.rdy;
    end

    // Stage two: per-port oldest pick among registered ready entries
    for (genvar p = 0; p < RS_PORTS; p++) begin : g_port
        logic [ENTRIES-1:0] elig;
        logic [ENTRIES-1:0] req_p;
        logic [ENTRIES-1:0] gnt_p;

        for (genvar i = 0; i < ENTRIES; i++) begin : g_elig
            assign elig[i] = port_serves(p, uop_q[i].op);
        end

        if (p == 0) begin : g_shared
            assign req_p = elig & ready_q & valid_q & ~gnt_alu1 & {ENTRIES{!port_busy[p]}};
        end else begin : g_own
            assign req_p = elig & ready_q & valid_q & {ENTRIES{!port_busy[p]}};
        end

        rs_oldest_pick #(.N(ENTRIES)) u_pick (
            .req   (req_p),
            .older (older),
            .gnt   (gnt_p)
        );

        if (p == 1) begin : g_alu_out
            assign gnt_alu1 = gnt_p;
        end

        assign gnt[p] = gnt_p;
    end

    always_comb begin
        taken_any = '0;
        pick_uop  = '0;
        for (int p = 0; p < RS_PORTS; p++) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (gnt[p][i]) begin
                    pick_uop[p]  = uop_q[i];
                    taken_any[i] = 1'b1;
                end
            end
        end
    end

    // Control state
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q  <= '0;
            ready_q  <= '0;
            disp_v_q <= '0;
        end else begin
            valid_q <= (valid_q & ~taken_any) | wr_en;
            ready_q <= ready_now & ~taken_any;
            for (int p = 0; p < RS_PORTS; p++) begin
                disp_v_q[p] <= |gnt[p];
            end
        end
    end

    // Payload storage and wakeup capture
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en[i]) begin
                uop_q[i] <= wr_uop[i];
            end else begin
                uop_q[i].s1 <= wake_src(uop_q[i].s1, wb_valid, wb_tag, wb_data);
                uop_q[i].s2 <= wake_src(uop_q[i].s2, wb_valid, wb_tag, wb_data);
            end
        end
        for (int p = 0; p < RS_PORTS; p++) begin
            disp_uop_q[p] <= pick_uop[p];
        end
    end

    assign disp_valid = disp_v_q;

    for (genvar p = 0; p < RS_PORTS; p++) begin : g_out
        assign disp_op[p]   = disp_uop_q[p].op;
        assign disp_dst[p]  = disp_uop_q[p].dst;
        assign disp_src1[p] = disp_uop_q[p].s1.val;
        assign disp_src2[p] = disp_uop_q[p].s2.val;
    end

endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk
    import rs_pkg::*;
#(
    parameter int ENTRIES = 20,
    parameter int LANES   = 3
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             flush,
    input logic                             alloc_stall,
    input logic [RS_PORTS-1:0]              port_busy,
    input logic [RS_PORTS-1:0]              disp_valid,
    input logic [RS_PORTS-1:0][RS_OP_W-1:0] disp_op,
    input logic [ENTRIES-1:0]               occ,
    input logic [ENTRIES-1:0]               rdy
);

    for (genvar p = 0; p < RS_PORTS; p++) begin : g_chk
        AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
            port_busy[p] |=> !disp_valid[p]);                                      // R6
        AST_PORT_CLASS: assert property (@(posedge clk) disable iff (rst)
            disp_valid[p] |-> port_serves(p, disp_op[p]));                         // R4
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (occ == '0) && (disp_valid == '0));                              // R9

    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (alloc_stall && !flush) |=> $countones(occ) <= $past($countones(occ)));    // R8

    AST_FILL_RATE: assert property (@(posedge clk) disable iff (rst)
        $countones(occ) <= $past($countones(occ)) + LANES);                        // R8

    AST_DISP_FROM_READY: assert property (@(posedge clk) disable iff (rst)
        $countones(disp_valid) <= $past($countones(occ & rdy)));                   // R10

endmodule

bind rs_sched rs_sched_chk #(.ENTRIES(ENTRIES), .LANES(LANES)) i_rs_sched_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .alloc_stall (alloc_stall),
    .port_busy   (port_busy),
    .disp_valid  (disp_valid),
    .disp_op     (disp_op),
    .occ         (valid_q),
    .rdy         (ready_q)
);

// File: tb/test_rs_sched.sv
`timescale 1ns/1ps
module test_rs_sched;
    import rs_pkg::*;

    localparam int LANES = 3;

    logic                               clk = 1'b0;
    logic                               rst = 1'b1;
    logic                               flush = 1'b0;
    logic [LANES-1:0]                   alloc_valid = '0;
    logic [LANES-1:0][RS_OP_W-1:0]      alloc_op = '0;
    logic [LANES-1:0][RS_TAG_W-1:0]     alloc_dst = '0;
    logic [LANES-1:0][RS_TAG_W-1:0]     alloc_src1_tag = '0;
    logic [LANES-1:0]                   alloc_src1_rdy = '0;
    logic [LANES-1:0][RS_DATA_W-1:0]    alloc_src1_val = '0;
    logic [LANES-1:0][RS_TAG_W-1:0]     alloc_src2_tag = '0;
    logic [LANES-1:0]                   alloc_src2_rdy = '0;
    logic [LANES-1:0][RS_DATA_W-1:0]    alloc_src2_val = '0;
    logic                               alloc_stall;
    logic [RS_PORTS-1:0]                wb_valid = '0;
    logic [RS_PORTS-1:0][RS_TAG_W-1:0]  wb_tag = '0;
    logic [RS_PORTS-1:0][RS_DATA_W-1:0] wb_data = '0;
    logic [RS_PORTS-1:0]                port_busy = '0;
    logic [RS_PORTS-1:0]                disp_valid;
    logic [RS_PORTS-1:0][RS_OP_W-1:0]   disp_op;
    logic [RS_PORTS-1:0][RS_TAG_W-1:0]  disp_dst;
    logic [RS_PORTS-1:0][RS_DATA_W-1:0] disp_src1;
    logic [RS_PORTS-1:0][RS_DATA_W-1:0] disp_src2;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rs_sched i_rs_sched (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_dst(alloc_dst),
        .alloc_src1_tag(alloc_src1_tag), .alloc_src1_rdy(alloc_src1_rdy), .alloc_src1_val(alloc_src1_val),
        .alloc_src2_tag(alloc_src2_tag), .alloc_src2_rdy(alloc_src2_rdy), .alloc_src2_val(alloc_src2_val),
        .alloc_stall(alloc_stall),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .port_busy(port_busy),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_src1(disp_src1), .disp_src2(disp_src2)
    );

    task automatic chk(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(int k, op_class_e op, int dst, bit r1, int t1, int v1, bit r2, int t2, int v2);
        alloc_valid[k]    = 1'b1;
        alloc_op[k]       = op;
        alloc_dst[k]      = RS_TAG_W'(dst);
        alloc_src1_rdy[k] = r1;
        alloc_src1_tag[k] = RS_TAG_W'(t1);
        alloc_src1_val[k] = RS_DATA_W'(v1);
        alloc_src2_rdy[k] = r2;
        alloc_src2_tag[k] = RS_TAG_W'(t2);
        alloc_src2_val[k] = RS_DATA_W'(v2);
    endtask

    task automatic idle_inputs();
        alloc_valid = '0;
        wb_valid    = '0;
    endtask

    task automatic bcast(int bus, int tag, int data);
        wb_valid[bus] = 1'b1;
        wb_tag[bus]   = RS_TAG_W'(tag);
        wb_data[bus]  = RS_DATA_W'(data);
    endtask

    task automatic cleanup();
        idle_inputs();
        port_busy = '0;
        flush = 1'b1;
        tick();
        flush = 1'b0;
        tick();
    endtask

    // R1
    task automatic t_reset();
        chk("R1", "disp_valid after reset", int'(disp_valid), 0);
        alloc_valid = 3'b111;
        #1;
        chk("R1", "stall with empty scheduler", int'(alloc_stall), 0);
        alloc_valid = '0;
        #1;
    endtask

    // R2, R10
    task automatic t_basic();
        put(0, OP_LOAD, 5, 1, 0, 'h1111, 1, 0, 'h2222);
        tick();
        idle_inputs();
        tick();
        chk("R2", "no dispatch one edge after write", int'(disp_valid), 0);
        tick();
        chk("R2", "load on port 2", int'(disp_valid), 'b00100);
        chk("R2", "dst tag", int'(disp_dst[2]), 5);
        chk("R2", "op class", int'(disp_op[2]), int'(OP_LOAD));
        chk("R2", "src1 value", int'(disp_src1[2]), 'h1111);
        chk("R2", "src2 value", int'(disp_src2[2]), 'h2222);
        tick();
        chk("R10", "dispatched only once", int'(disp_valid), 0);
    endtask

    // R3
    task automatic t_wake();
        put(0, OP_STA, 7, 0, 9, 0, 1, 0, 'h33);
        tick();
        idle_inputs();
        tick();
        tick();
        chk("R3", "pending source holds uop", int'(disp_valid), 0);
        bcast(3, 9, 'hBEEF);
        tick();
        idle_inputs();
        tick();
        chk("R3", "no dispatch one edge after capture", int'(disp_valid), 0);
        tick();
        chk("R3", "woken store address on port 3", int'(disp_valid), 'b01000);
        chk("R3", "captured src1 value", int'(disp_src1[3]), 'hBEEF);
        chk("R3", "dst tag", int'(disp_dst[3]), 7);
        // capture in the write cycle
        put(0, OP_STD, 8, 1, 0, 'h44, 0, 12, 0);
        bcast(0, 12, 'h5A5A);
        tick();
        idle_inputs();
        tick();
        chk("R3", "same-cycle capture: not early", int'(disp_valid), 0);
        tick();
        chk("R3", "same-cycle capture dispatch on port 4", int'(disp_valid), 'b10000);
        chk("R3", "same-cycle captured src2", int'(disp_src2[4]), 'h5A5A);
        tick();
    endtask

    // R4, R5
    task automatic t_order();
        put(0, OP_IMUL, 10, 1, 0, 1, 1, 0, 2);
        put(1, OP_FP,   11, 1, 0, 3, 1, 0, 4);
        put(2, OP_AGU,  12, 1, 0, 5, 1, 0, 6);
        tick();
        idle_inputs();
        tick();
        tick();
        chk("R4", "port 0 only", int'(disp_valid), 'b00001);
        chk("R5", "lane 0 oldest first", int'(disp_dst[0]), 10);
        tick();
        chk("R5", "second oldest", int'(disp_dst[0]), 11);
        chk("R4", "fp class on port 0", int'(disp_op[0]), int'(OP_FP));
        tick();
        chk("R5", "third oldest", int'(disp_dst[0]), 12);
        tick();
        chk("R10", "port 0 drained", int'(disp_valid), 0);
    endtask

    // R7, R4, R5
    task automatic t_wide();
        put(0, OP_ALU,  1, 0, 20, 0, 1, 0, 9);
        put(1, OP_ALU,  2, 0, 20, 0, 1, 0, 9);
        put(2, OP_LOAD, 3, 0, 20, 0, 1, 0, 9);
        tick();
        idle_inputs();
        put(0, OP_STA, 4, 0, 20, 0, 1, 0, 9);
        put(1, OP_STD, 5, 0, 20, 0, 1, 0, 9);
        tick();
        idle_inputs();
        bcast(1, 20, 'h0707);
        tick();
        idle_inputs();
        tick();
        tick();
        chk("R7", "five ports together", int'(disp_valid), 'b11111);
        chk("R5", "older ALU on port 1", int'(disp_dst[1]), 1);
        chk("R4", "younger ALU on port 0", int'(disp_dst[0]), 2);
        chk("R4", "load port 2", int'(disp_dst[2]), 3);
        chk("R4", "sta port 3", int'(disp_dst[3]), 4);
        chk("R4", "std port 4", int'(disp_dst[4]), 5);
        chk("R3", "broadcast value on port 0", int'(disp_src1[0]), 'h0707);
        tick();
        chk("R10", "all drained", int'(disp_valid), 0);
    endtask

    // R6
    task automatic t_busy();
        port_busy = 5'b00110;
        put(0, OP_LOAD, 13, 1, 0, 1, 1, 0, 1);
        put(1, OP_ALU,  14, 1, 0, 1, 1, 0, 1);
        tick();
        idle_inputs();
        tick();
        tick();
        chk("R6", "ALU diverted to port 0 while port 1 busy", int'(disp_valid), 'b00001);
        chk("R6", "diverted dst", int'(disp_dst[0]), 14);
        for (int n = 0; n < 3; n++) begin
            tick();
            chk("R6", "busy port 2 holds load", int'(disp_valid), 0);
        end
        port_busy = '0;
        tick();
        chk("R6", "load leaves after release", int'(disp_valid), 'b00100);
        chk("R6", "released dst", int'(disp_dst[2]), 13);
        tick();
    endtask

    // R8, R5
    task automatic t_stall();
        for (int g = 0; g < 6; g++) begin
            for (int k = 0; k < 3; k++) put(k, OP_LOAD, g * 3 + k, 0, 30, 0, 1, 0, 0);
            tick();
        end
        idle_inputs();
        for (int k = 0; k < 3; k++) put(k, OP_LOAD, 40 + k, 0, 30, 0, 1, 0, 0);
        #1;
        chk("R8", "stall with 2 free and 3 lanes", int'(alloc_stall), 1);
        tick();
        idle_inputs();
        put(0, OP_LOAD, 18, 0, 30, 0, 1, 0, 0);
        put(1, OP_LOAD, 19, 0, 30, 0, 1, 0, 0);
        #1;
        chk("R8", "no stall with 2 free and 2 lanes", int'(alloc_stall), 0);
        tick();
        idle_inputs();
        put(0, OP_LOAD, 43, 0, 30, 0, 1, 0, 0);
        #1;
        chk("R8", "stall when full", int'(alloc_stall), 1);
        tick();
        idle_inputs();
        bcast(2, 30, 'h00AA);
        tick();
        idle_inputs();
        tick();
        chk("R8", "nothing before release order", int'(disp_valid), 0);
        for (int n = 0; n < 20; n++) begin
            tick();
            chk("R5", "port 2 dispatch in allocation order", int'(disp_valid), 'b00100);
            chk("R5", "allocation order dst", int'(disp_dst[2]), n);
        end
        tick();
        chk("R8", "stalled lanes were never written", int'(disp_valid), 0);
    endtask

    // R9
    task automatic t_flush();
        put(0, OP_LOAD, 50, 1, 0, 1, 1, 0, 1);
        put(1, OP_STA,  51, 0, 33, 0, 1, 0, 1);
        tick();
        idle_inputs();
        flush = 1'b1;
        tick();
        flush = 1'b0;
        chk("R9", "dispatch cleared at flush edge", int'(disp_valid), 0);
        tick();
        chk("R9", "flushed ready uop never leaves", int'(disp_valid), 0);
        bcast(3, 33, 'h1);
        tick();
        idle_inputs();
        tick();
        tick();
        chk("R9", "flushed waiting uop never leaves", int'(disp_valid), 0);
        for (int g = 0; g < 7; g++) begin
            for (int k = 0; k < 3; k++) begin
                if (g * 3 + k < 20) put(k, OP_STD, g * 3 + k, 0, 40, 0, 0, 40, 0);
            end
            #1;
            chk("R9", "all entries free after flush", int'(alloc_stall), 0);
            tick();
            idle_inputs();
        end
        put(0, OP_STD, 60, 0, 40, 0, 0, 40, 0);
        #1;
        chk("R9", "refill reaches exactly twenty", int'(alloc_stall), 1);
        idle_inputs();
        cleanup();
    endtask

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_basic();
        t_wake();
        t_order();
        t_wide();
        t_busy();
        t_stall();
        t_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL all: watchdog expired, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule